// File: doc/BRIEF.md
# Word queue manager with programmable watermarks

This block runs a set of circular word queues that all live in one shared on-chip RAM. Each queue is described by a single packed 32-bit configuration word. That word holds the ring's position in RAM, its length, its two watermark codes, and its live read and write indices. A register-bus write to a queue's access address appends one word to that queue. A register-bus read from the same address removes the oldest word and returns it one cycle later.

For every queue the block works out the fill level. From that level it derives four flags: empty, nearly empty, nearly full and full. Nearly empty and nearly full compare against thresholds that software programs. The flags of eight queues are packed into each status word. An access that cannot be honoured does not stall the bus. Instead it leaves the queue untouched and latches a sticky error bit. A pop from an empty queue latches an underflow bit, and a push into a full queue latches an overflow bit. Software clears these bits by writing 1 to them.

Top module: `wordq_manager`

## Requirements
- R1: After reset every status field reads 0x3 (empty and nearly empty), every error word reads 0 and every configuration word reads 0.
- R2: The configuration word of queue q sits at word address 32+q and reads back as written. The write index is in bits 6:0, the read index in bits 13:7, the base in bits 21:14, an entry-size code in bits 23:22 (stored only), the ring-size code in bits 25:24, the nearly-empty code in bits 28:26 and the nearly-full code in bits 31:29. After each accepted push or pop, the matching index field reads back advanced by one.
- R3: A write to access address q (word address q) stores the word in RAM at word (base*16 + write index). A read from that address returns words in FIFO order, taken from (base*16 + read index). Queues whose RAM windows do not overlap do not disturb each other, and two queues configured over the same window see the same words.
- R4: The ring holds 16<<code words. Both indices wrap from size-1 to 0, and a hidden wrap bit per index tells a full ring apart from an empty one.
- R5: Empty is set exactly when the fill level is 0, and full exactly when the fill level equals the ring size.
- R6: A threshold code c maps to T = 0 when c is 0, and to 2^(c-1) entries otherwise. Nearly empty is set when the fill level is at most T(nearly-empty code).
- R7: Nearly full is set when the free space (ring size minus fill) is at most T(nearly-full code).
- R8: Status word k (word address 64+k) holds queue 8k+j in bits 4j+3:4j. Within each field, bit0 is empty, bit1 nearly empty, bit2 nearly full and bit3 full. Writes to status words have no effect.
- R9: A pop from an empty queue returns 0, leaves the read index unchanged and sets the underflow bit of queue q. That bit is bit 2*(q mod 16) of error word q/16 (word address 80+q/16).
- R10: A push into a full queue drops the word, leaves the write index and the stored words unchanged, and sets the overflow bit of queue q at bit 2*(q mod 16)+1 of error word q/16.
- R11: Writing an error word clears each sticky bit whose written value is 1 and leaves the bits written as 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request, 0 otherwise |

## Verification
The bench uses the default build of eight queues over a 256-word RAM. With eight queues, one status word and one error word cover every queue, so each check can compare a whole packed word against the model. A 256-word RAM fits rings of 16, 32 and 64 words side by side at distinct bases. It also leaves room for a deliberate overlay, where a second queue configured over an existing window must drain the first queue's words, which checks the base-times-16 placement. The short 16-word rings make index wrap-around, the full/empty boundary and both watermark edges reachable within a few dozen accesses.

// File: rtl/wq_pkg.sv
package wq_pkg;

   localparam int CFG_W   = 32;
   localparam int IDX_W   = 7;
   localparam int LVL_W   = 8;
   localparam int MIN_RING = 16;

   // packed per-queue descriptor, msb first
   typedef struct packed {
      logic [2:0]       nf_code;
      logic [2:0]       ne_code;
      logic [1:0]       size_code;
      logic [1:0]       esz_code;
      logic [7:0]       base;
      logic [IDX_W-1:0] rd_idx;
      logic [IDX_W-1:0] wr_idx;
   } qcfg_t;

   // status nibble, bit3..bit0
   typedef struct packed {
      logic full;
      logic near_full;
      logic near_empty;
      logic empty;
   } qlvl_t;

   function automatic logic [IDX_W-1:0] ring_mask(input logic [1:0] code);
      return IDX_W'((MIN_RING << code) - 1);
   endfunction

   function automatic logic [LVL_W-1:0] thr_entries(input logic [2:0] code);
      return (code == 3'd0) ? '0 : (LVL_W'(1) << (code - 3'd1));
   endfunction

endpackage

// File: rtl/wq_ram.sv
module wq_ram #(
   parameter  int WORDS = 256,
   parameter  int DW    = 32,
   localparam int AW    = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/wq_level.sv
module wq_level
   import wq_pkg::*;
(
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             wrap_w,
   input  logic             wrap_r,
   input  logic [1:0]       size_code,
   input  logic [2:0]       ne_code,
   input  logic [2:0]       nf_code,
   output qlvl_t            lvl,
   output logic [LVL_W-1:0] fill
);

   logic [IDX_W-1:0] mask;
   logic [LVL_W-1:0] ring, w8, r8, space;

   assign mask  = ring_mask(size_code);
   assign ring  = {1'b0, mask} + LVL_W'(1);
   assign w8    = {1'b0, wr_idx & mask};
   assign r8    = {1'b0, rd_idx & mask};

   // equal wrap bits: same lap; differing: writer one lap ahead
   assign fill  = (wrap_w == wrap_r) ? (w8 - r8) : (ring - r8 + w8);
   assign space = ring - fill;

   always_comb begin
      lvl.empty      = (fill == '0);
      lvl.full       = (fill == ring);
      lvl.near_empty = (fill  <= thr_entries(ne_code));
      lvl.near_full  = (space <= thr_entries(nf_code));
   end

endmodule

// File: rtl/wq_bank.sv
module wq_bank
   import wq_pkg::*;
#(
   parameter  int NUM_Q = 8,
   localparam int QW    = $clog2(NUM_Q)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [QW-1:0]          op_q,
   input  logic                   cfg_we,
   input  logic [CFG_W-1:0]       cfg_wdata,
   input  logic                   push_ok,
   input  logic                   pop_ok,
   input  logic                   unf_set,
   input  logic                   ovf_set,
   input  logic                   err_we,
   input  logic                   err_sel,
   input  logic [CFG_W-1:0]       err_wdata,
   output qcfg_t [NUM_Q-1:0]      cfg_o,
   output logic  [NUM_Q-1:0]      wrap_w_o,
   output logic  [NUM_Q-1:0]      wrap_r_o,
   output logic  [NUM_Q-1:0]      uf_o,
   output logic  [NUM_Q-1:0]      of_o
);

   qcfg_t            new_cfg;
   logic [IDX_W-1:0] new_mask;
   logic             new_lapped;

   assign new_cfg    = qcfg_t'(cfg_wdata);
   assign new_mask   = ring_mask(new_cfg.size_code);
   // a loaded write index behind the read index means the writer has lapped
   assign new_lapped = (new_cfg.wr_idx & new_mask) < (new_cfg.rd_idx & new_mask);

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      localparam int EBIT = 2 * (q % 16);
      localparam int EWRD = q / 16;

      qcfg_t            cfg_r;
      logic             ww_r, wr_r, uf_r, of_r, hit, clr_hit;
      logic [IDX_W-1:0] mask, w_cur, r_cur;

      assign hit     = (int'(op_q) == q);
      assign clr_hit = err_we && (int'(err_sel) == EWRD);
      assign mask    = ring_mask(cfg_r.size_code);
      assign w_cur   = cfg_r.wr_idx & mask;
      assign r_cur   = cfg_r.rd_idx & mask;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_r <= '0;
            ww_r  <= 1'b0;
            wr_r  <= 1'b0;
            uf_r  <= 1'b0;
            of_r  <= 1'b0;
         end else begin
            if (cfg_we && hit) begin
               cfg_r <= new_cfg;
               ww_r  <= new_lapped;
               wr_r  <= 1'b0;
            end else begin
               if (push_ok && hit) begin
                  cfg_r.wr_idx <= (w_cur == mask) ? '0 : w_cur + IDX_W'(1);
                  if (w_cur == mask) ww_r <= ~ww_r;
               end
               if (pop_ok && hit) begin
                  cfg_r.rd_idx <= (r_cur == mask) ? '0 : r_cur + IDX_W'(1);
                  if (r_cur == mask) wr_r <= ~wr_r;
               end
            end
            if (clr_hit && err_wdata[EBIT])   uf_r <= 1'b0;
            if (clr_hit && err_wdata[EBIT+1]) of_r <= 1'b0;
            if (unf_set && hit) uf_r <= 1'b1;
            if (ovf_set && hit) of_r <= 1'b1;
         end
      end

      assign cfg_o[q]    = cfg_r;
      assign wrap_w_o[q] = ww_r;
      assign wrap_r_o[q] = wr_r;
      assign uf_o[q]     = uf_r;
      assign of_o[q]     = of_r;
   end

endmodule

// File: rtl/wordq_manager.sv
module wordq_manager
   import wq_pkg::*;
#(
   parameter int NUM_Q     = 8,
   parameter int RAM_WORDS = 256,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int QW        = $clog2(NUM_Q);
   localparam int RAW       = $clog2(RAM_WORDS);
   localparam int WINDOW    = 32;
   localparam int CFG_BASE  = WINDOW;
   localparam int STS_BASE  = 2 * WINDOW;
   localparam int ERR_BASE  = STS_BASE + 16;
   localparam int STS_WORDS = (NUM_Q + 7) / 8;
   localparam int ERR_WORDS = (NUM_Q + 15) / 16;

   // ---------------- elaboration checks ----------------
   if (NUM_Q < 2 || NUM_Q > WINDOW) begin : g_bad_nq
      $error("NUM_Q must lie in 2..32");
   end
   if (RAM_WORDS < MIN_RING || RAM_WORDS > 4096 || (RAM_WORDS & (RAM_WORDS - 1)) != 0) begin : g_bad_ram
      $error("RAM_WORDS must be a power of two in 16..4096");
   end
   if (ADDR_W < 7) begin : g_bad_aw
      $error("ADDR_W must be at least 7");
   end
   if (DATA_W != CFG_W) begin : g_bad_dw
      $error("DATA_W must equal the descriptor width");
   end

   // ---------------- address decode ----------------
   logic [31:0]   addr_i;
   logic [QW-1:0] acc_q;
   logic          acc_hit, cfg_hit, sts_hit, err_hit;
   logic          acc_rd, acc_wr;

   assign addr_i  = 32'(bus_addr);
   assign acc_q   = bus_addr[QW-1:0];
   assign acc_hit = bus_valid && (addr_i < 32'(NUM_Q));
   assign cfg_hit = bus_valid && (addr_i >= 32'(CFG_BASE)) && (addr_i < 32'(CFG_BASE + NUM_Q));
   assign sts_hit = bus_valid && (addr_i >= 32'(STS_BASE)) && (addr_i < 32'(STS_BASE + STS_WORDS));
   assign err_hit = bus_valid && (addr_i >= 32'(ERR_BASE)) && (addr_i < 32'(ERR_BASE + ERR_WORDS));
   assign acc_rd  = acc_hit && !bus_write;
   assign acc_wr  = acc_hit &&  bus_write;

   // ---------------- per-queue state and levels ----------------
   qcfg_t [NUM_Q-1:0] cfg_q;
   logic  [NUM_Q-1:0] wrap_w, wrap_r, uf_v, of_v;
   qlvl_t             lvl  [NUM_Q];
   logic [LVL_W-1:0]  fill [NUM_Q];

   logic push_ok, pop_ok, unf_set, ovf_set;

   assign push_ok = acc_wr && !lvl[acc_q].full;
   assign ovf_set = acc_wr &&  lvl[acc_q].full;
   assign pop_ok  = acc_rd && !lvl[acc_q].empty;
   assign unf_set = acc_rd &&  lvl[acc_q].empty;

   wq_bank #(.NUM_Q(NUM_Q)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_q      (acc_q),
      .cfg_we    (cfg_hit && bus_write),
      .cfg_wdata (bus_wdata),
      .push_ok   (push_ok),
      .pop_ok    (pop_ok),
      .unf_set   (unf_set),
      .ovf_set   (ovf_set),
      .err_we    (err_hit && bus_write),
      .err_sel   (bus_addr[0]),
      .err_wdata (bus_wdata),
      .cfg_o     (cfg_q),
      .wrap_w_o  (wrap_w),
      .wrap_r_o  (wrap_r),
      .uf_o      (uf_v),
      .of_o      (of_v)
   );

   for (genvar q = 0; q < NUM_Q; q++) begin : g_lvl
      wq_level u_lvl (
         .wr_idx    (cfg_q[q].wr_idx),
         .rd_idx    (cfg_q[q].rd_idx),
         .wrap_w    (wrap_w[q]),
         .wrap_r    (wrap_r[q]),
         .size_code (cfg_q[q].size_code),
         .ne_code   (cfg_q[q].ne_code),
         .nf_code   (cfg_q[q].nf_code),
         .lvl       (lvl[q]),
         .fill      (fill[q])
      );

      // fill can never exceed the ring length (R5)
      p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
         fill[q] <= ({1'b0, ring_mask(cfg_q[q].size_code)} + LVL_W'(1)));
   end

   // ---------------- shared RAM ----------------
   logic [IDX_W-1:0] w_slot, r_slot;
   logic [RAW-1:0]   ram_waddr, ram_raddr;
   logic [DATA_W-1:0] ram_q;

   assign w_slot    = cfg_q[acc_q].wr_idx & ring_mask(cfg_q[acc_q].size_code);
   assign r_slot    = cfg_q[acc_q].rd_idx & ring_mask(cfg_q[acc_q].size_code);
   assign ram_waddr = RAW'((12'(cfg_q[acc_q].base) << 4) + 12'(w_slot));
   assign ram_raddr = RAW'((12'(cfg_q[acc_q].base) << 4) + 12'(r_slot));

   wq_ram #(.WORDS(RAM_WORDS), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (push_ok),
      .waddr (ram_waddr),
      .wdata (bus_wdata),
      .re    (pop_ok),
      .raddr (ram_raddr),
      .rdata (ram_q)
   );

   // ---------------- packed status and error words ----------------
   logic [3:0][31:0] sts_word;
   logic [1:0][31:0] err_word;

   for (genvar s = 0; s < WINDOW; s++) begin : g_pack
      if (s < NUM_Q) begin : g_live
         assign sts_word[s/8][4*(s%8) +: 4]  = lvl[s];
         assign err_word[s/16][2*(s%16) +: 2] = {of_v[s], uf_v[s]};
      end else begin : g_idle
         assign sts_word[s/8][4*(s%8) +: 4]  = 4'h0;
         assign err_word[s/16][2*(s%16) +: 2] = 2'b00;
      end
   end

   // ---------------- read path ----------------
   logic [DATA_W-1:0] reg_mux, reg_q;
   logic              src_mem;

   always_comb begin
      reg_mux = '0;
      if (cfg_hit)      reg_mux = cfg_q[acc_q];
      else if (sts_hit) reg_mux = sts_word[bus_addr[1:0]];
      else if (err_hit) reg_mux = err_word[bus_addr[0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_mem <= 1'b0;
         reg_q   <= '0;
      end else begin
         src_mem <= pop_ok;
         reg_q   <= (bus_valid && !bus_write) ? reg_mux : '0;
      end
   end

   assign bus_rdata = src_mem ? ram_q : reg_q;

   // ---------------- access-rule assertions ----------------
   p_underflow_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && lvl[acc_q].empty) |=> uf_v[$past(acc_q)]);

   p_underflow_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && lvl[acc_q].empty) |=> (bus_rdata == '0));

   p_underflow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && lvl[acc_q].empty) |=>
         (cfg_q[$past(acc_q)].rd_idx == $past(cfg_q[acc_q].rd_idx)));

   p_overflow_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && lvl[acc_q].full) |=> of_v[$past(acc_q)]);

   p_overflow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && lvl[acc_q].full) |=>
         (cfg_q[$past(acc_q)].wr_idx == $past(cfg_q[acc_q].wr_idx)));

   p_push_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && !lvl[acc_q].full) |=>
         (cfg_q[$past(acc_q)].wr_idx != $past(cfg_q[acc_q].wr_idx)));

endmodule

// File: tb/tb_wordq_manager.sv
`timescale 1ns/1ps
module tb_wordq_manager;

   localparam int NQ    = 8;
   localparam int A_CFG = 32;
   localparam int A_STS = 64;
   localparam int A_ERR = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int total = 0;
   int bad   = 0;

   // reference model
   logic [31:0] mq [NQ][$];
   int          msize [NQ];
   int          mne   [NQ];
   int          mnf   [NQ];
   logic        muf   [NQ];
   logic        mof   [NQ];

   always #2.5 clk = ~clk;

   wordq_manager dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'(a); bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'(a);
      @(negedge clk);
      d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   function automatic int thr(input int c);
      return (c == 0) ? 0 : (1 << (c - 1));
   endfunction

   function automatic logic [3:0] exp_field(input int q);
      int c = mq[q].size();
      logic [3:0] f;
      f[0] = (c == 0);
      f[1] = (c <= thr(mne[q]));
      f[2] = ((msize[q] - c) <= thr(mnf[q]));
      f[3] = (c == msize[q]);
      return f;
   endfunction

   function automatic logic [31:0] exp_sts_word();
      logic [31:0] w = '0;
      for (int q = 0; q < NQ; q++) w[4*q +: 4] = exp_field(q);
      return w;
   endfunction

   function automatic logic [31:0] exp_err_word();
      logic [31:0] w = '0;
      for (int q = 0; q < NQ; q++) w[2*q +: 2] = {mof[q], muf[q]};
      return w;
   endfunction

   task automatic cfg_set(input int q, input int base, input int szc, input int nec,
                          input int nfc, input int wr, input int rd);
      logic [31:0] w;
      w = {3'(nfc), 3'(nec), 2'(szc), 2'b00, 8'(base), 7'(rd), 7'(wr)};
      bus_wr(A_CFG + q, w);
      msize[q] = 16 << szc; mne[q] = nec; mnf[q] = nfc;
      mq[q].delete();
   endtask

   task automatic push(input int q, input logic [31:0] d);
      bus_wr(q, d);
      if (mq[q].size() < msize[q]) mq[q].push_back(d);
      else mof[q] = 1'b1;
   endtask

   task automatic pop_chk(input int q, input string tag);
      logic [31:0] got, exp;
      bus_rd(q, got);
      if (mq[q].size() == 0) begin exp = '0; muf[q] = 1'b1; end
      else exp = mq[q].pop_front();
      check(tag, got, exp);
   endtask

   task automatic sts_chk(input int q, input string tag);
      logic [31:0] got;
      bus_rd(A_STS + q / 8, got);
      check(tag, 32'(got[4*(q%8) +: 4]), 32'(exp_field(q)));
   endtask

   task automatic word_chk(input string tag);
      logic [31:0] got;
      bus_rd(A_STS, got);
      check({tag, " status word"}, got, exp_sts_word());
      bus_rd(A_ERR, got);
      check({tag, " error word"}, got, exp_err_word());
   endtask

   task automatic t_reset();
      logic [31:0] got;
      bus_rd(A_STS, got); check("R1 status after reset", got, 32'h3333_3333);
      bus_rd(A_ERR, got); check("R1 errors after reset", got, 32'h0);
      bus_rd(A_CFG + 5, got); check("R1 config after reset", got, 32'h0);
   endtask

   task automatic t_config();
      logic [31:0] got;
      cfg_set(0, 0, 0, 2, 2, 0, 0);
      cfg_set(1, 1, 1, 3, 1, 0, 0);
      cfg_set(2, 3, 2, 0, 0, 0, 0);
      cfg_set(3, 7, 0, 1, 3, 0, 0);
      bus_rd(A_CFG + 1, got);
      check("R2 config readback", got, {3'd1, 3'd3, 2'd1, 2'd0, 8'd1, 7'd0, 7'd0});
      word_chk("R8 after config");
   endtask

   task automatic t_fill_drain();
      logic [31:0] got;
      for (int i = 0; i < 16; i++) begin
         push(0, 32'h1000 + i);
         sts_chk(0, "R5 R6 R7 fill q0");
      end
      push(0, 32'hDEAD_BEEF);
      bus_rd(A_ERR, got); check("R10 overflow bit", got, exp_err_word());
      sts_chk(0, "R10 still full");
      bus_rd(A_CFG + 0, got);
      check("R2 R4 wr index wrapped", 32'(got[13:0]), 32'h0);
      for (int i = 0; i < 16; i++) begin
         pop_chk(0, "R3 R10 drain order");
         sts_chk(0, "R5 R6 R7 drain q0");
      end
      pop_chk(0, "R9 underflow returns zero");
      bus_rd(A_ERR, got); check("R9 underflow bit", got, exp_err_word());
      bus_rd(A_CFG + 0, got);
      check("R9 rd index held", 32'(got[13:7]), 32'h0);
   endtask

   task automatic t_clear();
      logic [31:0] got;
      bus_wr(A_ERR, 32'h0);
      bus_rd(A_ERR, got); check("R11 zero write keeps bits", got, 32'h3);
      bus_wr(A_ERR, 32'h1); muf[0] = 1'b0;
      bus_rd(A_ERR, got); check("R11 clear underflow only", got, 32'h2);
      bus_wr(A_ERR, 32'h2); mof[0] = 1'b0;
      bus_rd(A_ERR, got); check("R11 clear overflow", got, 32'h0);
      bus_wr(A_STS, 32'h0);
      word_chk("R8 status write ignored");
   endtask

   task automatic t_wrap();
      logic [31:0] got;
      int n = 0;
      for (int r = 0; r < 10; r++) begin
         for (int k = 0; k < 3; k++) begin push(3, 32'h3000 + n); n++; end
         pop_chk(3, "R4 wrap data");
         pop_chk(3, "R4 wrap data");
         sts_chk(3, "R6 R7 wrap level");
      end
      bus_rd(A_CFG + 3, got);
      check("R2 R4 indices after wrap", 32'(got[13:0]), {18'd0, 7'd4, 7'd14});
      for (int k = 0; k < 10; k++) pop_chk(3, "R4 wrap drain");
      sts_chk(3, "R5 empty after wrap");
   endtask

   task automatic t_interleave();
      for (int i = 0; i < 20; i++) begin
         push(1, 32'h5100 + i);
         push(2, 32'h5200 + i);
      end
      word_chk("R8 two queues loaded");
      for (int i = 0; i < 20; i++) begin
         pop_chk(2, "R3 isolation q2");
         pop_chk(1, "R3 isolation q1");
      end
      word_chk("R8 two queues drained");
   endtask

   task automatic t_alias();
      cfg_set(3, 7, 0, 1, 3, 0, 0);
      for (int i = 0; i < 5; i++) push(3, 32'hA0 + i);
      cfg_set(4, 7, 0, 0, 0, 5, 0);
      for (int i = 0; i < 5; i++) mq[4].push_back(32'hA0 + i);
      sts_chk(4, "R3 R6 alias level");
      for (int i = 0; i < 5; i++) pop_chk(4, "R3 base placement");
      sts_chk(4, "R5 alias empty");
   endtask

   initial begin
      for (int q = 0; q < NQ; q++) begin
         msize[q] = 16; mne[q] = 0; mnf[q] = 0; muf[q] = 1'b0; mof[q] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_config();
      t_fill_drain();
      t_clear();
      t_wrap();
      t_interleave();
      t_alias();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule